// File: doc/BRIEF.md
# Two-Pad Open-Drain Line Control Register

This block holds the control word for one pair of bidirectional pads, a clock line and a data line, that software toggles by hand to run a two-wire serial bus. Each line is open-drain. Software pulls a line low by making its pad an output that drives 0. It releases the line by turning the pad back into an input, so an external pull-up lifts it. Every pad input is brought into the clock domain through a synchronizer and can be read back from the same word.

Each line is a small state machine whose state is the pair {direction, value}. The four states are `PAD_FLOAT_LO` (input, value 0), `PAD_FLOAT_HI` (input, value 1), `PAD_DRIVE_LO` (output, value 0) and `PAD_DRIVE_HI` (output, value 1). A register write moves a line between any two of these states. The direction half of the state changes only when its strobe bit is set in that write, and the value half changes only when its own strobe is set. When neither strobe is set, the line stays in its current state. Because the strobe bits sit in the written word next to the fields they guard, one write can change the clock line and leave the data line alone, or the other way round.

The word is 32 bits wide. The clock line occupies a 6-bit lane that starts at bit 0, and the data line occupies the same lane layout starting at bit 8. Within a lane, at offset +n from the lane's start bit: +0 is the direction (1 = output), +1 is the direction strobe, +2 is the value, +3 is the value strobe, +4 is the synchronized pad input (read only) and +5 disables the pull-up (1 = disabled). All other bits read as 0.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset, both lines are in `PAD_FLOAT_LO`: pad output enables and output values are 0, both pull-up disable bits are 0, and no lane bit other than the input bit (+4) reads 1.
- R2: The direction bit (+0) of a lane takes the written value at the clock edge of a write only when the direction strobe (+1) of that lane is 1 in the same write. Otherwise it keeps its value.
- R3: The value bit (+2) of a lane takes the written value only when the value strobe (+3) of that lane is 1 in the same write. Otherwise it keeps its value.
- R4: Writing direction 0 with the direction strobe set releases the line: the pad output enable is 0 after that edge.
- R5: Writing direction 1 and value 0, with both strobes set, drives the line low: the output enable is 1 and the output value is 0 after that edge.
- R6: A write that sets no strobe of one lane leaves that lane's pad outputs and read-back fields unchanged.
- R7: The pull-up disable bit (+5) of each lane is loaded from every write, with no strobe, and reads back as written.
- R8: The strobe bits (+1, +3) always read as 0.
- R9: The input bit (+4) shows the pad input level after exactly two rising clock edges, and not after one.
- R10: A write whose only set bit is a strobe is accepted: the guarded field becomes 0, and the input bit of that lane stays readable on the following read.
- R11: The pad output enable equals the read-back direction bit, and the pad output value equals the read-back value bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; loads `wr_data` on the rising edge |
| wr_data | input | 32 | Write word using the lane layout |
| rd_data | output | 32 | Read-back word (combinational from state) |
| ck_pad_in | input | 1 | Clock-line pad input level |
| dt_pad_in | input | 1 | Data-line pad input level |
| ck_pad_oe | output | 1 | Clock-line pad output enable |
| ck_pad_out | output | 1 | Clock-line pad output value |
| dt_pad_oe | output | 1 | Data-line pad output enable |
| dt_pad_out | output | 1 | Data-line pad output value |
| ck_pu_dis | output | 1 | Clock-line pull-up disable |
| dt_pu_dis | output | 1 | Data-line pull-up disable |

## Verification
The hardest case to reach is a line that the block itself is driving low, which is then released by a write that carries only its direction strobe, while the pad input is still held low from outside. Here the read-back input must follow the pad and not the earlier drive. The bench drives the clock line low, pulls its pad input low, and issues the bare-strobe write. It then reads the input bit after the synchronizer has settled, and again after the outside party lets the line go. For the synchronizer timing, the bench changes a pad input between clock edges and samples the read-back after one edge and after two edges.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    // Offsets of the fields inside one lane of the control word
    localparam int OFS_DIR      = 0;
    localparam int OFS_DIR_STB  = 1;
    localparam int OFS_VAL      = 2;
    localparam int OFS_VAL_STB  = 3;
    localparam int OFS_IN       = 4;
    localparam int OFS_PU_DIS   = 5;
    localparam int LANE_FIELD_W = 6;

    // Line state encoded as {direction, value}
    typedef enum logic [1:0] {
        PAD_FLOAT_LO = 2'b00,
        PAD_FLOAT_HI = 2'b01,
        PAD_DRIVE_LO = 2'b10,
        PAD_DRIVE_HI = 2'b11
    } pad_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_lane.sv
module gpio_pad_lane
    import gpio_pair_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LANE_FIELD_W-1:0] wr_field,
    input  logic                    pad_in,
    output logic                    pad_oe,
    output logic                    pad_out,
    output logic                    pu_dis,
    output logic [LANE_FIELD_W-1:0] rd_field
);

    pad_state_e state_q;
    pad_state_e state_d;
    logic       pu_q;
    logic       in_sync;
    logic       dir_next;
    logic       val_next;

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    // Next state: each half of the state moves only under its own strobe
    always_comb begin
        dir_next = state_q[1];
        val_next = state_q[0];
        if (wr_en && wr_field[OFS_DIR_STB]) begin
            dir_next = wr_field[OFS_DIR];
        end
        if (wr_en && wr_field[OFS_VAL_STB]) begin
            val_next = wr_field[OFS_VAL];
        end
        state_d = pad_state_e'({dir_next, val_next});
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAD_FLOAT_LO;
            pu_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                pu_q <= wr_field[OFS_PU_DIS];
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            PAD_FLOAT_LO: begin pad_oe = 1'b0; pad_out = 1'b0; end
            PAD_FLOAT_HI: begin pad_oe = 1'b0; pad_out = 1'b1; end
            PAD_DRIVE_LO: begin pad_oe = 1'b1; pad_out = 1'b0; end
            PAD_DRIVE_HI: begin pad_oe = 1'b1; pad_out = 1'b1; end
            default:      begin pad_oe = 1'b0; pad_out = 1'b0; end
        endcase
    end

    assign pu_dis = pu_q;

    always_comb begin
        rd_field              = '0;
        rd_field[OFS_DIR]     = state_q[1];
        rd_field[OFS_VAL]     = state_q[0];
        rd_field[OFS_IN]      = in_sync;
        rd_field[OFS_PU_DIS]  = pu_q;
    end

endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int LANE_STRIDE = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ck_pad_in,
    input  logic             dt_pad_in,
    output logic             ck_pad_oe,
    output logic             ck_pad_out,
    output logic             dt_pad_oe,
    output logic             dt_pad_out,
    output logic             ck_pu_dis,
    output logic             dt_pu_dis
);

    localparam int LANES = 2;

    logic [LANES-1:0]        lane_in;
    logic [LANES-1:0]        lane_oe;
    logic [LANES-1:0]        lane_out;
    logic [LANES-1:0]        lane_pu;
    logic [LANE_FIELD_W-1:0] lane_rd [LANES];
    logic                    unused_wr;

    assign lane_in  = {dt_pad_in, ck_pad_in};
    assign unused_wr = ^wr_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        gpio_pad_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_field (wr_data[g*LANE_STRIDE +: LANE_FIELD_W]),
            .pad_in   (lane_in[g]),
            .pad_oe   (lane_oe[g]),
            .pad_out  (lane_out[g]),
            .pu_dis   (lane_pu[g]),
            .rd_field (lane_rd[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < LANES; i++) begin
            rd_data[i*LANE_STRIDE +: LANE_FIELD_W] = lane_rd[i];
        end
    end

    assign ck_pad_oe  = lane_oe[0];
    assign ck_pad_out = lane_out[0];
    assign ck_pu_dis  = lane_pu[0];
    assign dt_pad_oe  = lane_oe[1];
    assign dt_pad_out = lane_out[1];
    assign dt_pu_dis  = lane_pu[1];

endmodule

// File: rtl/gpio_pair_ctrl_chk.sv
module gpio_pair_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        ck_pad_in,
    input logic        ck_pad_oe,
    input logic        ck_pad_out,
    input logic        dt_pad_oe,
    input logic        dt_pad_out,
    input logic        ck_pu_dis,
    input logic        dt_pu_dis
);

    logic [1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (settle_q != 2'd3) begin
            settle_q <= settle_q + 2'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ck_pad_oe && !dt_pad_oe && !ck_pu_dis && !dt_pu_dis));

    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[1]) |=> (ck_pad_oe == $past(ck_pad_oe)));

    a_r3_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[3]) |=> (ck_pad_out == $past(ck_pad_out)));

    a_r5_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && wr_data[1] && !wr_data[2] && wr_data[3])
        |=> (ck_pad_oe && !ck_pad_out));

    a_r6_lane_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[9] && !wr_data[11])
        |=> (dt_pad_oe == $past(dt_pad_oe) && dt_pad_out == $past(dt_pad_out)));

    a_r9_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 2'd2) |-> (rd_data[4] == $past(ck_pad_in, 2)));

endmodule

bind gpio_pair_ctrl gpio_pair_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .ck_pad_in  (ck_pad_in),
    .ck_pad_oe  (ck_pad_oe),
    .ck_pad_out (ck_pad_out),
    .dt_pad_oe  (dt_pad_oe),
    .dt_pad_out (dt_pad_out),
    .ck_pu_dis  (ck_pu_dis),
    .dt_pu_dis  (dt_pu_dis)
);

// File: tb/tb_gpio_pair_ctrl.sv
module tb_gpio_pair_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // write word, expected read-back, expected {ck_oe, ck_out, dt_oe, dt_out}
    localparam logic [31:0] VEC_WR  [NVEC] = '{32'h0000_000B, 32'h0000_0B00,
        32'h0000_0002, 32'h0000_0001, 32'h0000_0C00, 32'h0000_2020,
        32'h0000_0200, 32'h0000_080C};
    localparam logic [31:0] VEC_RD  [NVEC] = '{32'h0000_1011, 32'h0000_1111,
        32'h0000_1110, 32'h0000_1110, 32'h0000_1510, 32'h0000_3530,
        32'h0000_1410, 32'h0000_1014};
    localparam logic [3:0]  VEC_PAD [NVEC] = '{4'b1000, 4'b1010, 4'b0010,
        4'b0010, 4'b0011, 4'b0011, 4'b0001, 4'b0100};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ck_pad_in = 1'b1;
    logic        dt_pad_in = 1'b1;
    logic        ck_pad_oe, ck_pad_out, dt_pad_oe, dt_pad_out;
    logic        ck_pu_dis, dt_pu_dis;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pair_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ck_pad_in  (ck_pad_in),
        .dt_pad_in  (dt_pad_in),
        .ck_pad_oe  (ck_pad_oe),
        .ck_pad_out (ck_pad_out),
        .dt_pad_oe  (dt_pad_oe),
        .dt_pad_out (dt_pad_out),
        .ck_pu_dis  (ck_pu_dis),
        .dt_pu_dis  (dt_pu_dis)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [3:0] pads();
        return {ck_pad_oe, ck_pad_out, dt_pad_oe, dt_pad_out};
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pads in reset", {28'd0, pads()}, 32'd0);
        check("R1 read in reset", rd_data, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 read after reset", rd_data, 32'h0000_1010);
        check("R1 pull-ups enabled", {30'd0, ck_pu_dis, dt_pu_dis}, 32'd0);

        // Table: R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC_WR[i]);
            check("R2/R3/R6/R7/R8 read-back", rd_data, VEC_RD[i]);
            check("R4/R5/R11 pad outputs", {28'd0, pads()}, {28'd0, VEC_PAD[i]});
        end

        // R11: pad outputs match read-back fields
        check("R11 ck oe vs dir", {31'd0, ck_pad_oe}, {31'd0, rd_data[0]});
        check("R11 dt out vs val", {31'd0, dt_pad_out}, {31'd0, rd_data[10]});

        // R9: two-edge synchronizer latency
        @(negedge clk);
        ck_pad_in = 1'b0;
        @(negedge clk);
        check("R9 after one edge", {31'd0, rd_data[4]}, 32'd1);
        @(negedge clk);
        check("R9 after two edges", {31'd0, rd_data[4]}, 32'd0);
        ck_pad_in = 1'b1;
        repeat (2) @(negedge clk);

        // R10: drive low, pad held low outside, bare-strobe release
        write_word(32'h0000_000B);
        check("R10 driven low", {28'd0, pads()}, 32'h0000_0008);
        ck_pad_in = 1'b0;
        write_word(32'h0000_0002);
        check("R10 released by bare strobe", {31'd0, ck_pad_oe}, 32'd0);
        @(negedge clk);
        check("R10 input readable low", {31'd0, rd_data[4]}, 32'd0);
        ck_pad_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 input readable high", {31'd0, rd_data[4]}, 32'd1);
        check("R10 full word", rd_data, 32'h0000_1010);

        // R2/R3: value strobe only leaves direction; direction strobe only leaves value
        write_word(32'h0000_0004);
        check("R3 value without strobe ignored", rd_data, 32'h0000_1010);
        write_word(32'h0000_0008);
        check("R3 bare value strobe clears", rd_data, 32'h0000_1010);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule